// File: doc/BRIEF.md
# Banked 24-bit Memory Address Decoder

This block is the glue between a 16-bit processor and up to three memory modules on a single-board computer. The processor drives only sixteen address lines. In the first half of each bus cycle, while the phase-2 clock is low, it places the upper eight address bits (the bank byte) on its data bus. The block captures that byte and joins it to the sixteen CPU lines to form a 24-bit memory address.

From that address it derives all the memory selects. The top two bits pick a module. That field, together with the read/write line, drives two small decoders: one produces the per-module output-enable strobes and the other the per-module write-enable strobes. The next three bits pick one of eight active-low chip enables. The block also drives the direction and enable pins of the bidirectional data buffer between the CPU and memory.

Every enable is active low. Strobes fire only while phase-2 is high and the CPU flags a valid address. The block sits on a fast system clock, `clk`. The bank byte is sampled on `clk` edges while phase-2 is low, and the last sample is held while phase-2 is high. The pins are plain control lines, with no valid/ready handshake: the CPU bus cannot be stalled, so there is no back-pressure to signal.

Top module: `banked_addr_decoder`

## Requirements
- R1: While `phi2` is 0 and reset is released, `mem_addr[23:16]` follows `cpu_data` combinationally, and `mem_addr[15:0]` always equals `cpu_addr`.
- R2: While `phi2` is 1, `mem_addr[23:16]` holds the `cpu_data` value sampled at the last `clk` rising edge at which `phi2` was 0. Changes on `cpu_data` during that time have no effect.
- R3: The module code is `mem_addr[23:22]`. Codes 0, 1 and 2 select module 0, 1 and 2, the strobe bit index being the code. Code 3 is unpopulated: every bit of `oe_n`, `we_n` and `ce_n` stays 1.
- R4: With `rw`=1 (read) only `oe_n[code]` may go low, and with `rw`=0 (write) only `we_n[code]`. At no time is more than one of the six strobe bits low.
- R5: A strobe goes low only when `phi2`=1 and `vda`=1. In every other case all of `oe_n` and `we_n` are 1.
- R6: `ce_n[k]` is 0 exactly when `vda`=1, the module code is populated and `mem_addr[21:19]` equals k. At most one `ce_n` bit is low, and `phi2` does not gate it.
- R7: `buf_dir` equals `rw` (1 = memory drives the CPU side). `buf_en_n` is 0 exactly when `phi2`=1 and reset is released.
- R8: While `rst_n`=0, `oe_n`, `we_n` and `ce_n` are all ones, `buf_en_n` is 1 and `mem_addr[23:16]` is 0.
- R9: `cpu_addr` has no effect on `oe_n`, `we_n`, `ce_n`, `buf_dir` or `buf_en_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bank byte |
| rst_n | input | 1 | Active-low reset |
| phi2 | input | 1 | CPU phase-2 clock level |
| vda | input | 1 | CPU valid-address qualifier, 1 = address valid |
| rw | input | 1 | CPU read/write, 1 = read |
| cpu_addr | input | 16 | Address lines driven directly by the CPU |
| cpu_data | input | 8 | CPU data bus, carrying the bank byte while phi2 is low |
| mem_addr | output | 24 | Full memory address: bank byte above the CPU lines |
| oe_n | output | 3 | Per-module output-enable strobes, active low |
| we_n | output | 3 | Per-module write-enable strobes, active low |
| ce_n | output | 8 | Device chip enables, active low |
| buf_dir | output | 1 | Data buffer direction, 1 = memory to CPU |
| buf_en_n | output | 1 | Data buffer enable, active low |

## Verification
A wrong bank register appears on `mem_addr[23:16]` in the same phase-2-high half cycle. It also moves the strobe and chip-enable selection in that half cycle, so a single bus cycle exposes it. A wrong gating term shows up either as a strobe during phase-2 low or as both an output-enable and a write-enable low together. The bench walks all 256 bank values under both directions, both qualifier levels and several CPU address patterns. It compares every enable pin against values computed from the address bits in both halves of each cycle, so any such fault is caught within the cycle in which it occurs.

// File: rtl/banked_decode_pkg.sv
package banked_decode_pkg;

  typedef enum logic {
    BUS_WRITE = 1'b0,
    BUS_READ  = 1'b1
  } bus_dir_e;

endpackage

// File: rtl/bank_capture.sv
module bank_capture #(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic [BANK_W-1:0] data_in,
  output logic [BANK_W-1:0] bank
);

  logic [BANK_W-1:0] bank_q;

  // Sample while phase-2 is low; freeze once it rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank_q <= '0;
    else if (!phi2) bank_q <= data_in;
  end

  // Open (transparent) in the address half, held in the data half.
  always_comb begin
    if (!rst_n)    bank = '0;
    else if (phi2) bank = bank_q;
    else           bank = data_in;
  end

  a_r2_hold_in_data_phase : assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && $past(phi2)) |-> $stable(bank_q));

endmodule

// File: rtl/strobe_decoder.sv
module strobe_decoder #(
  parameter int   SEL_W    = 2,
  parameter int   NUM_OUT  = 3,
  parameter logic FIRE_DIR = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               rw,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_OUT-1:0] strobe_n
);

  logic fire;
  assign fire = enable && (rw == FIRE_DIR);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    localparam logic [SEL_W-1:0] CODE = SEL_W'(i);
    assign strobe_n[i] = !(fire && (sel == CODE));
  end

  a_r5_quiet_when_disabled : assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (&strobe_n));
  a_r4_one_strobe_max : assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~strobe_n) <= 1);

endmodule

// File: rtl/chip_select_decoder.sv
module chip_select_decoder #(
  parameter int SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic [SEL_W-1:0]      sel,
  output logic [(1<<SEL_W)-1:0] ce_n
);

  localparam int NUM_CE = 1 << SEL_W;

  for (genvar k = 0; k < NUM_CE; k++) begin : g_ce
    localparam logic [SEL_W-1:0] CODE = SEL_W'(k);
    assign ce_n[k] = !(enable && (sel == CODE));
  end

  a_r6_ce_onehot0 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n));
  a_r6_ce_when_enabled : assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> ($countones(~ce_n) == 1));

endmodule

// File: rtl/banked_addr_decoder.sv
module banked_addr_decoder #(
  parameter int ADDR_LO_W   = 16,
  parameter int BANK_W      = 8,
  parameter int MOD_SEL_W   = 2,
  parameter int NUM_MODULES = 3,
  parameter int CE_SEL_W    = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           phi2,
  input  logic                           vda,
  input  logic                           rw,
  input  logic [ADDR_LO_W-1:0]           cpu_addr,
  input  logic [BANK_W-1:0]              cpu_data,
  output logic [ADDR_LO_W+BANK_W-1:0]    mem_addr,
  output logic [NUM_MODULES-1:0]         oe_n,
  output logic [NUM_MODULES-1:0]         we_n,
  output logic [(1<<CE_SEL_W)-1:0]       ce_n,
  output logic                           buf_dir,
  output logic                           buf_en_n
);
  import banked_decode_pkg::*;

  localparam int MOD_MSB = BANK_W - 1;
  localparam int CE_MSB  = BANK_W - MOD_SEL_W - 1;
  localparam logic [MOD_SEL_W:0] POPULATED = (MOD_SEL_W+1)'(NUM_MODULES);

  logic [BANK_W-1:0]    bank;
  logic [MOD_SEL_W-1:0] mod_sel;
  logic [CE_SEL_W-1:0]  ce_sel;
  logic                 mod_present;
  logic                 strobe_en;
  logic                 ce_en;

  bank_capture #(.BANK_W(BANK_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .phi2    (phi2),
    .data_in (cpu_data),
    .bank    (bank)
  );

  assign mem_addr    = {bank, cpu_addr};
  assign mod_sel     = bank[MOD_MSB -: MOD_SEL_W];
  assign ce_sel      = bank[CE_MSB -: CE_SEL_W];
  assign mod_present = ({1'b0, mod_sel} < POPULATED);
  assign strobe_en   = rst_n && phi2 && vda;
  assign ce_en       = rst_n && vda && mod_present;

  // Read-side decoder: fires on reads only.
  strobe_decoder #(
    .SEL_W(MOD_SEL_W), .NUM_OUT(NUM_MODULES), .FIRE_DIR(BUS_READ)
  ) u_oe_dec (
    .clk(clk), .rst_n(rst_n), .enable(strobe_en), .rw(rw),
    .sel(mod_sel), .strobe_n(oe_n)
  );

  // Write-side decoder: same select, opposite read/write sense.
  strobe_decoder #(
    .SEL_W(MOD_SEL_W), .NUM_OUT(NUM_MODULES), .FIRE_DIR(BUS_WRITE)
  ) u_we_dec (
    .clk(clk), .rst_n(rst_n), .enable(strobe_en), .rw(rw),
    .sel(mod_sel), .strobe_n(we_n)
  );

  chip_select_decoder #(.SEL_W(CE_SEL_W)) u_ce_dec (
    .clk(clk), .rst_n(rst_n), .enable(ce_en), .sel(ce_sel), .ce_n(ce_n)
  );

  assign buf_dir  = rw;
  assign buf_en_n = !(rst_n && phi2);

  a_r4_read_write_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
    (&oe_n) || (&we_n));
  a_r3_unpopulated_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    (vda && !mod_present) |-> ((&oe_n) && (&we_n) && (&ce_n)));
  a_r7_buffer_closed_low_phase : assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> buf_en_n);
  a_r5_no_strobe_low_phase : assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> ((&oe_n) && (&we_n)));

  always_comb begin
    if (!rst_n) a_r8_reset_quiet : assert ((&oe_n) && (&we_n) && (&ce_n) && buf_en_n);
  end

endmodule

// File: tb/banked_addr_decoder_tb_top.sv
module banked_addr_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phi2 = 1'b1;
  logic        vda = 1'b1;
  logic        rw = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [23:0] mem_addr;
  logic [2:0]  oe_n, we_n;
  logic [7:0]  ce_n;
  logic        buf_dir, buf_en_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_addr_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .vda(vda), .rw(rw),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data), .mem_addr(mem_addr),
    .oe_n(oe_n), .we_n(we_n), .ce_n(ce_n), .buf_dir(buf_dir), .buf_en_n(buf_en_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_oe(logic [7:0] b, bit r, bit v, bit p);
    if (v && p && r && b[7:6] != 2'd3) return ~(3'b001 << b[7:6]);
    return 3'b111;
  endfunction

  function automatic logic [2:0] exp_we(logic [7:0] b, bit r, bit v, bit p);
    if (v && p && !r && b[7:6] != 2'd3) return ~(3'b001 << b[7:6]);
    return 3'b111;
  endfunction

  function automatic logic [7:0] exp_ce(logic [7:0] b, bit v);
    if (v && b[7:6] != 2'd3) return ~(8'b1 << b[5:3]);
    return 8'hFF;
  endfunction

  task automatic check_pins(input logic [7:0] b, input logic [15:0] a,
                            input bit r, input bit v, input bit p);
    chk(mem_addr == {b, a}, p ? "R2 held bank" : "R1 address assembly",
        32'(mem_addr), 32'({b, a}));
    chk(oe_n == exp_oe(b, r, v, p), "R4/R5/R3/R9 oe_n", 32'(oe_n), 32'(exp_oe(b, r, v, p)));
    chk(we_n == exp_we(b, r, v, p), "R4/R5/R3/R9 we_n", 32'(we_n), 32'(exp_we(b, r, v, p)));
    chk(ce_n == exp_ce(b, v), "R6/R3 ce_n", 32'(ce_n), 32'(exp_ce(b, v)));
    chk(buf_dir == r, "R7 buf_dir", 32'(buf_dir), 32'(r));
    chk(buf_en_n == !p, "R7 buf_en_n", 32'(buf_en_n), 32'(!p));
  endtask

  task automatic bus_cycle(input logic [7:0] b, input logic [15:0] a,
                           input bit r, input bit v);
    @(negedge clk);
    phi2 = 1'b0; cpu_data = b; cpu_addr = a; rw = r; vda = v;
    #1 check_pins(b, a, r, v, 1'b0);
    @(negedge clk);
    phi2 = 1'b1; cpu_data = ~b;   // bus turns to data; bank must hold (R2)
    #1 check_pins(b, a, r, v, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [3];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3;
    // R8: reset with an otherwise active read to module 0.
    repeat (3) @(negedge clk);
    #1;
    chk(oe_n == 3'b111 && we_n == 3'b111, "R8 strobes in reset", 32'({oe_n, we_n}), 32'h3F);
    chk(ce_n == 8'hFF, "R8 ce_n in reset", 32'(ce_n), 32'hFF);
    chk(buf_en_n == 1'b1, "R8 buf_en_n in reset", 32'(buf_en_n), 32'h1);
    chk(mem_addr[23:16] == 8'h00, "R8 bank in reset", 32'(mem_addr[23:16]), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int b = 0; b < 256; b++)
      for (int r = 0; r < 2; r++)
        for (int v = 0; v < 2; v++)
          for (int p = 0; p < 3; p++)
            bus_cycle(8'(b), pats[p], r[0], v[0]);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule